// File: doc/BRIEF.md
# Delay-Slot Branch Unit

This block is the next-PC logic of a small command-processing microcontroller. Each retiring instruction is presented for one cycle with `step_i` high, together with its PC, the decoded control-transfer fields and the value of its source register. The unit returns the PC of the next instruction to fetch. Conditional branches come in an equality form, which compares the source against a zero-extended 5-bit immediate, and a bit-test form, which examines one selected source bit. Relative targets use a signed 16-bit offset. Absolute jumps and calls take a full target, and returns pop a small hardware return stack.

Every control transfer has exactly one delay slot. The instruction after a branch, jump, call or return always retires. The redirect takes effect on the step after the delay slot. A control operation placed in a delay slot is treated as illegal. It raises a sticky error and has no effect. Because a compare result encodes ordering in separate bits, pairing it with the bit-test form gives ordered comparisons such as less-than-or-equal. An unconditional relative jump is an equality test of the always-zero register against 0.

Top module: `dslot_branch_unit`

## Requirements
- R1: After synchronous active-high reset, `in_slot_o` is 0, `depth_o` is 0, all three error flags are 0, and a step with `op_i`=0 (no control transfer) gives `next_pc_o` = `pc_i`+1 and `taken_o` = 0.
- R2: Equality form (`bit_form_i`=0): `op_i`=1 (branch-if-equal) is taken when `src_i` equals `imm_i` zero-extended to 32 bits. `op_i`=2 (branch-if-not-equal) is taken when they differ. A source of 0 tested for equality with 0 is always taken.
- R3: Bit-test form (`bit_form_i`=1): `imm_i` selects bit number `imm_i` of `src_i`. `op_i`=1 is taken when that bit is 1, and `op_i`=2 is taken when that bit is 0.
- R4: The target of a conditional branch is `pc_i` plus `offset_i` sign-extended, modulo 2^PC_W (PC_W = 20).
- R5: On the step of a legal control operation, `next_pc_o` is `pc_i`+1 and `taken_o` shows whether it redirects. On the next step, `in_slot_o` is 1 and `next_pc_o` is the saved target if the operation was taken, otherwise `pc_i`+1.
- R6: `op_i`=3 (jump) is always taken, with target `abs_tgt_i`.
- R7: `op_i`=4 (call) is taken to `abs_tgt_i` and pushes `pc_i`+2. `op_i`=5 (return) is taken to the most recent pushed address and pops it. Nesting to 4 levels returns in last-in first-out order, and `depth_o` counts the entries.
- R8: A call made while 4 entries are held still redirects, but it leaves the stack and `depth_o` unchanged and sets the sticky `ovf_err_o`.
- R9: A return made while the stack is empty is not taken and sets the sticky `unf_err_o`.
- R10: A control operation made while `in_slot_o` is 1 does not redirect, push or pop. It sets the sticky `slot_err_o` and does not open a new slot. That step still follows the earlier branch's redirect.
- R11: While `step_i` is 0, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | An instruction retires this cycle |
| pc_i | input | 20 | PC of the retiring instruction |
| op_i | input | 3 | 0 none, 1 branch-if-equal, 2 branch-if-not-equal, 3 jump, 4 call, 5 return |
| bit_form_i | input | 1 | 1 selects the bit-test form of a conditional branch |
| imm_i | input | 5 | Compare immediate or bit number |
| offset_i | input | 16 | Signed relative branch offset |
| abs_tgt_i | input | 20 | Absolute target for jump and call |
| src_i | input | 32 | Source register value |
| next_pc_o | output | 20 | PC of the next instruction |
| taken_o | output | 1 | The current operation will redirect after its slot |
| in_slot_o | output | 1 | The current step is a delay slot |
| depth_o | output | 3 | Return stack occupancy |
| ovf_err_o | output | 1 | Sticky return stack overflow |
| unf_err_o | output | 1 | Sticky return stack underflow |
| slot_err_o | output | 1 | Sticky control operation in delay slot |

## Verification
The hardest situations to reach are those in which two stack limits or two slots interact. Examples are a fifth call on a full stack followed by four returns that must still unwind the original four addresses, and a call placed in the slot of a taken branch that must neither push nor cancel the pending redirect. Directed tasks reach these states by issuing exact sequences of calls, each with its delay-slot step. After each sequence they read `depth_o` and the `next_pc_o` of each following step, so stack contents are observed through the returns themselves.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_BEQ  = 3'd1,
        OP_BNE  = 3'd2,
        OP_JMP  = 3'd3,
        OP_CALL = 3'd4,
        OP_RET  = 3'd5
    } ctl_op_e;

    function automatic logic is_ctl(input ctl_op_e op);
        return (op == OP_BEQ) || (op == OP_BNE) || (op == OP_JMP) ||
               (op == OP_CALL) || (op == OP_RET);
    endfunction

    function automatic logic is_cond(input ctl_op_e op);
        return (op == OP_BEQ) || (op == OP_BNE);
    endfunction

endpackage

// File: rtl/dsb_cond_eval.sv
module dsb_cond_eval
    import dsb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5
) (
    input  ctl_op_e           op_i,
    input  logic              bit_form_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] src_i,
    output logic              cond_o
);
    logic match;
    logic sel_bit;

    always_comb begin
        sel_bit = src_i[imm_i];
        match   = bit_form_i ? sel_bit : (src_i == DATA_W'(imm_i));
        cond_o  = (op_i == OP_BEQ) ? match : !match;
    end

    // R3: the bit-test form ignores every source bit except the selected one
    always_comb begin
        if (bit_form_i && op_i == OP_BEQ)
            a_r3_bit_select: assert (cond_o == src_i[imm_i]);
    end
endmodule

// File: rtl/dsb_target_calc.sv
module dsb_target_calc #(
    parameter int PC_W  = 20,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic [PC_W-1:0]  rel_tgt_o,
    output logic [PC_W-1:0]  seq_pc_o,
    output logic [PC_W-1:0]  ret_pc_o
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;

    always_comb begin
        off_ext   = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
        rel_tgt_o = pc_i + off_ext;
        seq_pc_o  = pc_i + PC_W'(1);
        ret_pc_o  = pc_i + PC_W'(2);
    end
endmodule

// File: rtl/dsb_ret_stack.sv
module dsb_ret_stack #(
    parameter int PC_W  = 20,
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push_i,
    input  logic                        pop_i,
    input  logic [PC_W-1:0]             data_i,
    output logic [PC_W-1:0]             top_o,
    output logic [$clog2(DEPTH+1)-1:0]  depth_o,
    output logic                        empty_o,
    output logic                        ovf_o,
    output logic                        unf_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PC_W-1:0]  mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_m1;
    logic             full;

    always_comb begin
        full    = (cnt == CNT_W'(DEPTH));
        empty_o = (cnt == '0);
        cnt_m1  = cnt - CNT_W'(1);
        top_o   = empty_o ? '0 : mem[cnt_m1[IDX_W-1:0]];
        depth_o = cnt;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (push_i && !full && cnt == CNT_W'(g))
                mem[g] <= data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            if (push_i) begin
                if (full) ovf_o <= 1'b1;
                else      cnt   <= cnt + CNT_W'(1);
            end else if (pop_i) begin
                if (empty_o) unf_o <= 1'b1;
                else         cnt   <= cnt_m1;
            end
        end
    end

    a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));
    a_r7_push_grows: assert property (@(posedge clk) disable iff (rst)
        push_i && !full |=> depth_o == $past(depth_o) + CNT_W'(1));
    a_r8_full_push_flags: assert property (@(posedge clk) disable iff (rst)
        push_i && full |=> ovf_o && $stable(depth_o));
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);
    a_r9_empty_pop_flags: assert property (@(posedge clk) disable iff (rst)
        pop_i && empty_o |=> unf_o && depth_o == '0);
    a_r9_unf_sticky: assert property (@(posedge clk) disable iff (rst)
        unf_o |=> unf_o);
endmodule

// File: rtl/dslot_branch_unit.sv
module dslot_branch_unit
    import dsb_pkg::*;
#(
    parameter int PC_W     = 20,
    parameter int DATA_W   = 32,
    parameter int OFF_W    = 16,
    parameter int IMM_W    = 5,
    parameter int RS_DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           step_i,
    input  logic [PC_W-1:0]                pc_i,
    input  logic [2:0]                     op_i,
    input  logic                           bit_form_i,
    input  logic [IMM_W-1:0]               imm_i,
    input  logic [OFF_W-1:0]               offset_i,
    input  logic [PC_W-1:0]                abs_tgt_i,
    input  logic [DATA_W-1:0]              src_i,
    output logic [PC_W-1:0]                next_pc_o,
    output logic                           taken_o,
    output logic                           in_slot_o,
    output logic [$clog2(RS_DEPTH+1)-1:0]  depth_o,
    output logic                           ovf_err_o,
    output logic                           unf_err_o,
    output logic                           slot_err_o
);
    ctl_op_e         op;
    logic            cond;
    logic            legal;
    logic            stk_empty;
    logic [PC_W-1:0] rel_tgt, seq_pc, ret_pc, stk_top, tgt;
    logic            slot_q, redir_q;
    logic [PC_W-1:0] tgt_q;

    assign op = ctl_op_e'(op_i);

    dsb_cond_eval #(.DATA_W(DATA_W), .IMM_W(IMM_W)) cond_i (
        .op_i(op), .bit_form_i(bit_form_i), .imm_i(imm_i),
        .src_i(src_i), .cond_o(cond)
    );

    dsb_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) tcalc_i (
        .pc_i(pc_i), .offset_i(offset_i), .rel_tgt_o(rel_tgt),
        .seq_pc_o(seq_pc), .ret_pc_o(ret_pc)
    );

    dsb_ret_stack #(.PC_W(PC_W), .DEPTH(RS_DEPTH)) stack_i (
        .clk(clk), .rst(rst),
        .push_i(legal && op == OP_CALL),
        .pop_i(legal && op == OP_RET),
        .data_i(ret_pc), .top_o(stk_top), .depth_o(depth_o),
        .empty_o(stk_empty), .ovf_o(ovf_err_o), .unf_o(unf_err_o)
    );

    always_comb begin
        legal = step_i && is_ctl(op) && !slot_q;
        tgt   = rel_tgt;
        unique case (op)
            OP_JMP, OP_CALL: tgt = abs_tgt_i;
            OP_RET:          tgt = stk_top;
            default:         tgt = rel_tgt;
        endcase
        if (!legal)            taken_o = 1'b0;
        else if (is_cond(op))  taken_o = cond;
        else if (op == OP_RET) taken_o = !stk_empty;
        else                   taken_o = 1'b1;
        next_pc_o = (slot_q && redir_q) ? tgt_q : seq_pc;
        in_slot_o = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q     <= 1'b0;
            redir_q    <= 1'b0;
            tgt_q      <= '0;
            slot_err_o <= 1'b0;
        end else if (step_i) begin
            slot_q  <= legal;
            redir_q <= taken_o;
            tgt_q   <= tgt;
            if (slot_q && is_ctl(op))
                slot_err_o <= 1'b1;
        end
    end

    a_r5_slot_opens: assert property (@(posedge clk) disable iff (rst)
        step_i && is_ctl(op) && !in_slot_o |=> in_slot_o);
    a_r5_redirect_lands: assert property (@(posedge clk) disable iff (rst)
        step_i && taken_o |=> next_pc_o == $past(tgt));
    a_r10_slot_ctl_rejected: assert property (@(posedge clk) disable iff (rst)
        step_i && in_slot_o && is_ctl(op) |=> slot_err_o && !in_slot_o);
    a_r10_slot_err_sticky: assert property (@(posedge clk) disable iff (rst)
        slot_err_o |=> slot_err_o);
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(in_slot_o) && $stable(depth_o));
endmodule

// File: tb/dslot_branch_unit_tb_top.sv
module dslot_branch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        step;
    logic [19:0] pc;
    logic [2:0]  op;
    logic        bitf;
    logic [4:0]  imm;
    logic [15:0] off;
    logic [19:0] abs_t;
    logic [31:0] src;
    logic [19:0] next_pc;
    logic        taken, in_slot, ovf, unf, serr;
    logic [2:0]  depth;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dslot_branch_unit dut_i (
        .clk(clk), .rst(rst), .step_i(step), .pc_i(pc), .op_i(op),
        .bit_form_i(bitf), .imm_i(imm), .offset_i(off), .abs_tgt_i(abs_t),
        .src_i(src), .next_pc_o(next_pc), .taken_o(taken),
        .in_slot_o(in_slot), .depth_o(depth), .ovf_err_o(ovf),
        .unf_err_o(unf), .slot_err_o(serr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // drive one retiring instruction; outputs are settled on return
    task automatic issue(input logic [2:0] o, input logic [19:0] p,
                         input logic bf = 0, input logic [4:0] im = 0,
                         input logic [15:0] of = 0, input logic [19:0] ab = 0,
                         input logic [31:0] s = 0);
        @(negedge clk);
        step = 1; op = o; pc = p; bitf = bf; imm = im; off = of; abs_t = ab; src = s;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; step = 0; op = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 in_slot", in_slot, 0);
        chk("R1 depth", depth, 0);
        chk("R1 errors", {ovf, unf, serr}, 0);
        issue(0, 20'h100);
        chk("R1 next_pc", next_pc, 20'h101);
        chk("R1 taken", taken, 0);
    endtask

    task automatic t_equality();
        do_reset();
        issue(1, 20'h200, 0, 5'd7, 16'h0010, 0, 32'd7);
        chk("R2 beq taken", taken, 1);
        chk("R5 branch step next_pc", next_pc, 20'h201);
        issue(0, 20'h201);
        chk("R5 in_slot", in_slot, 1);
        chk("R5 slot redirect", next_pc, 20'h210);
        issue(2, 20'h210, 0, 5'd7, 16'h0040, 0, 32'd7);
        chk("R2 bne equal not taken", taken, 0);
        issue(0, 20'h211);
        chk("R5 not taken slot falls through", next_pc, 20'h212);
        issue(2, 20'h212, 0, 5'd7, 16'h0040, 0, 32'd5);
        chk("R2 bne unequal taken", taken, 1);
        issue(0, 20'h213);
        issue(1, 20'h252, 0, 5'd7, 16'h0010, 0, 32'h27);
        chk("R2 upper bits break equality", taken, 0);
        issue(0, 20'h253);
        issue(1, 20'h254, 0, 5'd0, 16'h0100, 0, 32'd0);
        chk("R2 zero register jump", taken, 1);
        issue(0, 20'h255);
        chk("R2 zero register target", next_pc, 20'h354);
    endtask

    task automatic t_bit();
        do_reset();
        issue(1, 20'h400, 1, 5'd19, 16'h0008, 0, 32'h0008_0000);
        chk("R3 beq bit set", taken, 1);
        issue(0, 20'h401);
        issue(2, 20'h408, 1, 5'd19, 16'h0008, 0, 32'h0008_0000);
        chk("R3 bne bit set", taken, 0);
        issue(0, 20'h409);
        issue(2, 20'h40A, 1, 5'd0, 16'h0020, 0, 32'h8000_0002);
        chk("R3 bne bit clear", taken, 1);
        issue(0, 20'h40B);
        chk("R3 bne target", next_pc, 20'h42A);
        issue(1, 20'h42A, 1, 5'd31, 16'h0002, 0, 32'h7FFF_FFFF);
        chk("R3 beq bit31 clear", taken, 0);
        issue(0, 20'h42B);
    endtask

    task automatic t_relative();
        do_reset();
        issue(1, 20'h300, 0, 0, 16'hFFF0, 0, 0);
        issue(0, 20'h301);
        chk("R4 negative offset", next_pc, 20'h2F0);
        issue(1, 20'h00005, 0, 0, 16'hFFF8, 0, 0);
        issue(0, 20'h00006);
        chk("R4 wrap below zero", next_pc, 20'hFFFFD);
        issue(1, 20'hFFFF0, 0, 0, 16'h7FFF, 0, 0);
        issue(0, 20'hFFFF1);
        chk("R4 wrap above top", next_pc, 20'h07FEF);
    endtask

    task automatic t_jump();
        do_reset();
        issue(3, 20'h500, 0, 0, 16'h0004, 20'hABCDE, 0);
        chk("R6 jump taken", taken, 1);
        issue(0, 20'h501);
        chk("R6 jump absolute target", next_pc, 20'hABCDE);
    endtask

    task automatic t_call_ret();
        do_reset();
        issue(4, 20'h600, 0, 0, 0, 20'h800, 0);
        issue(0, 20'h601);
        chk("R7 call target", next_pc, 20'h800);
        chk("R7 depth one", depth, 1);
        issue(4, 20'h805, 0, 0, 0, 20'h900, 0);
        issue(0, 20'h806);
        chk("R7 depth two", depth, 2);
        issue(5, 20'h910);
        chk("R7 ret taken", taken, 1);
        issue(0, 20'h911);
        chk("R7 inner return", next_pc, 20'h807);
        issue(5, 20'h810);
        issue(0, 20'h811);
        chk("R7 outer return", next_pc, 20'h602);
        chk("R7 depth empty", depth, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 4; i++) begin
            issue(4, 20'h100 + 20'(i * 16), 0, 0, 0, 20'h100 + 20'((i + 1) * 16), 0);
            issue(0, 20'h101 + 20'(i * 16));
        end
        chk("R7 depth four", depth, 4);
        issue(4, 20'h140, 0, 0, 0, 20'hC00, 0);
        chk("R8 full call still taken", taken, 1);
        issue(0, 20'h141);
        chk("R8 full call target", next_pc, 20'hC00);
        chk("R8 depth held", depth, 4);
        chk("R8 ovf flag", ovf, 1);
        for (int i = 3; i >= 0; i--) begin
            issue(5, 20'hD00);
            issue(0, 20'hD01);
            chk("R8 original entries kept", next_pc, 20'h102 + 20'(i * 16));
        end
        chk("R8 ovf sticky", ovf, 1);
    endtask

    task automatic t_underflow();
        do_reset();
        issue(5, 20'h700);
        chk("R9 empty ret not taken", taken, 0);
        issue(0, 20'h701);
        chk("R9 falls through", next_pc, 20'h702);
        chk("R9 unf flag", unf, 1);
        chk("R9 depth zero", depth, 0);
    endtask

    task automatic t_slot_err();
        do_reset();
        issue(1, 20'hA00, 0, 0, 16'h0030, 0, 0);
        issue(3, 20'hA01, 0, 0, 0, 20'h12345, 0);
        chk("R10 slot jump no redirect", taken, 0);
        chk("R10 earlier branch honoured", next_pc, 20'hA30);
        issue(0, 20'hA30);
        chk("R10 no new slot", in_slot, 0);
        chk("R10 slot err", serr, 1);
        chk("R10 sequential after", next_pc, 20'hA31);
        issue(3, 20'hA31, 0, 0, 0, 20'hB00, 0);
        issue(4, 20'hA32, 0, 0, 0, 20'hF00, 0);
        issue(0, 20'hB00);
        chk("R10 slot call no push", depth, 0);
        chk("R10 slot err sticky", serr, 1);
    endtask

    task automatic t_idle();
        do_reset();
        @(negedge clk);
        step = 0; op = 3'd3; pc = 20'h050; abs_t = 20'h999;
        @(negedge clk);
        @(negedge clk);
        chk("R11 idle no slot", in_slot, 0);
        issue(0, 20'h051);
        chk("R11 idle no redirect", next_pc, 20'h052);
        issue(4, 20'h060, 0, 0, 0, 20'h700, 0);
        @(negedge clk);
        step = 0;
        @(negedge clk);
        chk("R11 slot held over idle", in_slot, 1);
        chk("R11 depth held", depth, 1);
        issue(0, 20'h061);
        chk("R11 redirect after idle", next_pc, 20'h700);
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; step = 0; op = 0; pc = 0; bitf = 0; imm = 0; off = 0; abs_t = 0; src = 0;
        t_reset();
        t_equality();
        t_bit();
        t_relative();
        t_jump();
        t_call_ret();
        t_overflow();
        t_underflow();
        t_slot_err();
        t_idle();
        finish_run();
    end
endmodule